// File: doc/BRIEF.md
# Lockstep Output Comparator and Inhibitor

This block guards the outputs of two redundant processor cores that run the same program clock for clock. Each cycle it receives an output bundle from the master core and an identical bundle from a checker core. Each bundle is a data word plus a valid strobe. Two independent comparators examine the pair bit by bit. The master's bundle is forwarded to the rest of the system only through an inhibitor. When the bundles disagree, the inhibitor blocks the outgoing data from that same cycle onward: data is forced to zero and valid is forced low. The checker's bundle is used only for comparison and never appears at the outputs.

Each comparator holds a small state machine with two states. In state ARMED it watches for a difference. The transition TRIP, taken on the first differing cycle, moves it to state TRIPPED. TRIPPED has no exit other than the system reset, so the trip indication is sticky and a transient fault is not lost.

The block also conditions the asynchronous inputs the cores need: interrupt, break, non-maskable break, core reset and bus reset. It puts each one through a two-stage synchronizer and hands one registered copy to both cores, so that both cores see the same value on the same edge. The two reset lines are asserted at once and released on the clock.

Top module: `lsc_guard`

## Requirements
- R1: While no trip is recorded, `rst_n` is high and both bundles are equal, `out_data` equals `m_data` and `out_valid` equals `m_valid` in the same cycle, with no register in the path.
- R2: A difference in any single bit of `{valid, data}` between the two bundles is a mismatch. In that same cycle `out_data` is all zeros and `out_valid` is low.
- R3: From the clock edge that ends the first mismatching cycle, both bits of `trip` are 1 (state TRIPPED), and `fault` (the OR of `trip`) is 1.
- R4: While `fault` is 1, `out_data` stays zero and `out_valid` stays low, even when the bundles agree again.
- R5: While `rst_n` is low, the outputs are blocked and `trip` is 0. A reset is the only way out of TRIPPED.
- R6: The outputs never carry the checker's bundle. With differing bundles, `out_data` is never equal to a nonzero `c_data`.
- R7: `irq_async`, `brk_async` and `nmbrk_async` appear on control bits 0, 1 and 2 after the second rising clock edge that follows a change, and not after the first.
- R8: Control bit 3 (core reset) and bit 4 (bus reset) rise without waiting for a clock edge when their asynchronous input is high or `rst_n` is low. They fall after the second rising edge once the input is low and `rst_n` is high.
- R9: `core_a_ctl` and `core_b_ctl` are equal at all times.
- R10: A single flipped bit at any of the 33 bundle positions, injected at any cycle, trips the block under R2 to R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | System reset, active low, asynchronous |
| m_data | input | W | Master core output data |
| m_valid | input | 1 | Master core output strobe |
| c_data | input | W | Checker core output data |
| c_valid | input | 1 | Checker core output strobe |
| irq_async | input | 1 | Asynchronous interrupt request |
| brk_async | input | 1 | Asynchronous break request |
| nmbrk_async | input | 1 | Asynchronous non-maskable break request |
| core_rst_async | input | 1 | Asynchronous core reset request, active high |
| bus_rst_async | input | 1 | Asynchronous bus reset request, active high |
| out_data | output | W | Inhibited data toward the system |
| out_valid | output | 1 | Inhibited strobe toward the system |
| trip | output | NCMP | Sticky trip flag of each comparator |
| fault | output | 1 | OR of all trip flags |
| core_a_ctl | output | 5 | Synchronized controls to the master core |
| core_b_ctl | output | 5 | Synchronized controls to the checker core |

## Verification
The inhibit on `out_data` and `out_valid` is combinational. The bench therefore checks it half a clock after it drives a bundle, before the next rising edge. `trip` and `fault` are due one rising edge after the first mismatching cycle, so they are checked low before that edge and high after it. Synchronized controls are due after the second rising edge, and the bench checks each of them both after the first edge, when it must still be unchanged, and after the second. The reset lines are also checked one nanosecond after their input rises, with no clock edge in between.

// File: rtl/lsc_pkg.sv
package lsc_pkg;

    typedef enum logic {
        CMP_ARMED   = 1'b0,
        CMP_TRIPPED = 1'b1
    } cmp_state_e;

    localparam int CTL_IRQ   = 0;
    localparam int CTL_BRK   = 1;
    localparam int CTL_NMBRK = 2;
    localparam int CTL_CRST  = 3;
    localparam int CTL_BRST  = 4;
    localparam int CTL_W     = 5;
    localparam int LVL_N     = 3;
    localparam int RST_N     = 2;

endpackage

// File: rtl/lsc_lvl_sync.sv
module lsc_lvl_sync #(
    parameter int N      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] async_i,
    output logic [N-1:0] sync_o
);
    logic [N-1:0] chain [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) chain[s] <= '0;
        end else begin
            chain[0] <= async_i;
            for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
        end
    end

    assign sync_o = chain[STAGES-1];
endmodule

// File: rtl/lsc_rst_sync.sv
module lsc_rst_sync #(
    parameter int N      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req_i,
    output logic [N-1:0] rst_o
);
    for (genvar g = 0; g < N; g++) begin : g_line
        logic              arst;
        logic [STAGES-1:0] sh;

        assign arst = req_i[g] | ~rst_n;

        always_ff @(posedge clk or posedge arst) begin
            if (arst) sh <= '1;
            else      sh <= {sh[STAGES-2:0], 1'b0};
        end

        assign rst_o[g] = sh[STAGES-1];
    end
endmodule

// File: rtl/lsc_cmp.sv
module lsc_cmp
    import lsc_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] a_data,
    input  logic         a_valid,
    input  logic [W-1:0] b_data,
    input  logic         b_valid,
    output logic         live_o,
    output logic         trip_o
);
    localparam int BW = W + 1;

    cmp_state_e   st_q, st_d;
    logic [BW-1:0] diff;

    assign diff   = {a_valid, a_data} ^ {b_valid, b_data};
    assign live_o = |diff;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= CMP_ARMED;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d   = st_q;
        trip_o = 1'b0;
        unique case (st_q)
            CMP_ARMED: begin
                trip_o = 1'b0;
                if (live_o) st_d = CMP_TRIPPED;
            end
            CMP_TRIPPED: begin
                trip_o = 1'b1;
                st_d   = CMP_TRIPPED;
            end
        endcase
    end
endmodule

// File: rtl/lsc_gate.sv
module lsc_gate #(
    parameter int W = 32
) (
    input  logic         block_i,
    input  logic [W-1:0] data_i,
    input  logic         valid_i,
    output logic [W-1:0] data_o,
    output logic         valid_o
);
    always_comb begin
        data_o  = block_i ? '0   : data_i;
        valid_o = block_i ? 1'b0 : valid_i;
    end
endmodule

// File: rtl/lsc_guard.sv
module lsc_guard
    import lsc_pkg::*;
#(
    parameter int W    = 32,
    parameter int NCMP = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [W-1:0]      m_data,
    input  logic              m_valid,
    input  logic [W-1:0]      c_data,
    input  logic              c_valid,
    input  logic              irq_async,
    input  logic              brk_async,
    input  logic              nmbrk_async,
    input  logic              core_rst_async,
    input  logic              bus_rst_async,
    output logic [W-1:0]      out_data,
    output logic              out_valid,
    output logic [NCMP-1:0]   trip,
    output logic              fault,
    output logic [CTL_W-1:0]  core_a_ctl,
    output logic [CTL_W-1:0]  core_b_ctl
);
    logic [NCMP-1:0]  live;
    logic             block;
    logic [LVL_N-1:0] lvl_s;
    logic [RST_N-1:0] rst_s;
    logic [CTL_W-1:0] ctl;

    for (genvar g = 0; g < NCMP; g++) begin : g_cmp
        lsc_cmp #(.W(W)) u_cmp (
            .clk     (clk),
            .rst_n   (rst_n),
            .a_data  (m_data),
            .a_valid (m_valid),
            .b_data  (c_data),
            .b_valid (c_valid),
            .live_o  (live[g]),
            .trip_o  (trip[g])
        );
    end

    assign fault = |trip;
    assign block = fault | (|live) | ~rst_n;

    lsc_gate #(.W(W)) u_gate (
        .block_i (block),
        .data_i  (m_data),
        .valid_i (m_valid),
        .data_o  (out_data),
        .valid_o (out_valid)
    );

    lsc_lvl_sync #(.N(LVL_N), .STAGES(2)) u_lvl (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({nmbrk_async, brk_async, irq_async}),
        .sync_o  (lvl_s)
    );

    lsc_rst_sync #(.N(RST_N), .STAGES(2)) u_rst (
        .clk   (clk),
        .rst_n (rst_n),
        .req_i ({bus_rst_async, core_rst_async}),
        .rst_o (rst_s)
    );

    assign ctl        = {rst_s, lvl_s};
    assign core_a_ctl = ctl;
    assign core_b_ctl = ctl;
endmodule

// File: rtl/lsc_guard_chk.sv
module lsc_guard_chk #(
    parameter int W    = 32,
    parameter int NCMP = 2
) (
    input logic            clk,
    input logic            rst_n,
    input logic [W-1:0]    m_data,
    input logic            m_valid,
    input logic [W-1:0]    c_data,
    input logic            c_valid,
    input logic            irq_async,
    input logic            brk_async,
    input logic            nmbrk_async,
    input logic            core_rst_async,
    input logic [W-1:0]    out_data,
    input logic            out_valid,
    input logic [NCMP-1:0] trip,
    input logic            fault,
    input logic [4:0]      core_a_ctl
);
    logic mism;
    assign mism = (m_data != c_data) || (m_valid != c_valid);

    p_pass_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!fault && !mism) |-> (out_data == m_data && out_valid == m_valid));

    p_block_now_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mism |-> (out_data == '0 && !out_valid));

    p_trip_next_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mism |=> (&trip && fault));

    p_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        fault |=> fault);

    p_hold_block_r4: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> (out_data == '0 && !out_valid));

    p_irq_lag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(core_a_ctl[0]) |-> $past(irq_async, 2));

    p_brk_lag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(core_a_ctl[1]) |-> $past(brk_async, 2));

    p_nmbrk_lag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(core_a_ctl[2]) |-> $past(nmbrk_async, 2));

    p_rst_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(core_a_ctl[3]) |-> (!$past(core_rst_async) && !$past(core_rst_async, 2)));
endmodule

bind lsc_guard lsc_guard_chk #(.W(W), .NCMP(NCMP)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .m_data         (m_data),
    .m_valid        (m_valid),
    .c_data         (c_data),
    .c_valid        (c_valid),
    .irq_async      (irq_async),
    .brk_async      (brk_async),
    .nmbrk_async    (nmbrk_async),
    .core_rst_async (core_rst_async),
    .out_data       (out_data),
    .out_valid      (out_valid),
    .trip           (trip),
    .fault          (fault),
    .core_a_ctl     (core_a_ctl)
);

// File: tb/lsc_guard_bench.sv
module lsc_guard_bench;
    localparam int W    = 32;
    localparam int NCMP = 2;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] m_data = '0, c_data = '0;
    logic         m_valid = 1'b0, c_valid = 1'b0;
    logic         irq_async = 1'b0, brk_async = 1'b0, nmbrk_async = 1'b0;
    logic         core_rst_async = 1'b0, bus_rst_async = 1'b0;
    logic [W-1:0] out_data;
    logic         out_valid;
    logic [NCMP-1:0] trip;
    logic         fault;
    logic [4:0]   core_a_ctl, core_b_ctl;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [31:0] lfsr = 32'h1ACE_B00C;

    always #10 clk = ~clk;

    lsc_guard #(.W(W), .NCMP(NCMP)) u_lsc_guard (
        .clk(clk), .rst_n(rst_n),
        .m_data(m_data), .m_valid(m_valid), .c_data(c_data), .c_valid(c_valid),
        .irq_async(irq_async), .brk_async(brk_async), .nmbrk_async(nmbrk_async),
        .core_rst_async(core_rst_async), .bus_rst_async(bus_rst_async),
        .out_data(out_data), .out_valid(out_valid), .trip(trip), .fault(fault),
        .core_a_ctl(core_a_ctl), .core_b_ctl(core_b_ctl)
    );

    // {valid, data} pairs driven identically on both bundles; expected output is the same pair
    localparam logic [32:0] VEC [8] = '{
        33'h1_0000_0001, 33'h1_FFFF_FFFF, 33'h0_DEAD_BEEF, 33'h1_8000_0000,
        33'h1_5555_AAAA, 33'h0_0000_0000, 33'h1_0F0F_F0F0, 33'h1_1234_5678
    };

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic next_rand();
        lfsr = lfsr ^ (lfsr << 13);
        lfsr = lfsr ^ (lfsr >> 17);
        lfsr = lfsr ^ (lfsr << 5);
    endtask

    task automatic copies_same();
        chk(core_a_ctl == core_b_ctl, "R9", 64'(core_a_ctl), 64'(core_b_ctl));
    endtask

    // drive matched pair after a falling edge, check mid-low phase
    task automatic drive_match(input logic [32:0] v, input bit expect_block, input string req);
        @(negedge clk);
        {m_valid, m_data} = v;
        {c_valid, c_data} = v;
        #5;
        if (expect_block)
            chk(out_data == '0 && !out_valid, req, {31'd0, out_valid, out_data}, 64'd0);
        else
            chk(out_data == v[31:0] && out_valid == v[32], req, {31'd0, out_valid, out_data}, {31'd0, v});
        copies_same();
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        {m_valid, m_data} = '0;
        {c_valid, c_data} = '0;
        #5;
        chk(trip == '0 && !fault, "R5 trip cleared", 64'(trip), 64'd0);
        chk(out_data == '0 && !out_valid, "R5 blocked in reset", {31'd0, out_valid, out_data}, 64'd0);
        chk(core_a_ctl[4:3] == 2'b11, "R8 reset lines held", 64'(core_a_ctl[4:3]), 64'd3);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(core_a_ctl[4:3] == 2'b11, "R8 release not after one edge", 64'(core_a_ctl[4:3]), 64'd3);
        @(negedge clk);
        chk(core_a_ctl[4:3] == 2'b00, "R8 release after two edges", 64'(core_a_ctl[4:3]), 64'd0);
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        do_reset();

        // R1: table of matched bundles passes through unchanged
        foreach (VEC[i]) begin
            drive_match(VEC[i], 1'b0, "R1 pass-through");
        end
        @(negedge clk);
        chk(!fault, "R1 no trip on matched data", 64'(fault), 64'd0);

        // R2 R3 R4 R6 R10: single-bit flip injected at pseudo-random cycles and positions
        for (int t = 0; t < 12; t++) begin
            int lead;
            int pos;
            logic [32:0] base;
            logic [32:0] flip;
            do_reset();
            next_rand();
            lead = 1 + int'(lfsr % 32'd12);
            next_rand();
            pos = (t == 0) ? 32 : (t == 1) ? 0 : int'(lfsr % 32'd33);
            for (int k = 0; k < lead; k++) begin
                next_rand();
                drive_match({1'b1, lfsr}, 1'b0, "R1 before injection");
            end
            next_rand();
            base = {1'b1, lfsr};
            flip = base ^ (33'd1 << pos);
            @(negedge clk);
            {m_valid, m_data} = base;
            {c_valid, c_data} = flip;
            #5;
            chk(out_data == '0 && !out_valid, "R2 same-cycle block", {31'd0, out_valid, out_data}, 64'd0);
            chk(trip == '0, "R3 no trip before edge", 64'(trip), 64'd0);
            if (c_data != '0)
                chk(out_data != c_data, "R6 checker data never forwarded", 64'(out_data), 64'(c_data));
            @(negedge clk);
            chk(trip == 2'b11 && fault, "R10 flip trips both comparators (R3)", {62'd0, trip}, 64'd3);
            {c_valid, c_data} = base;
            for (int k = 0; k < 3; k++) begin
                drive_match({1'b1, 32'hCAFE_0000 | 32'(k)}, 1'b1, "R4 stays blocked");
            end
            chk(fault, "R3 sticky", 64'(fault), 64'd1);
        end

        do_reset();
        drive_match(33'h1_ABCD_0123, 1'b0, "R5 reset clears trip, data flows");

        // R7: level synchronizers, two-edge lag
        @(negedge clk);
        irq_async = 1'b1;
        brk_async = 1'b1;
        @(negedge clk);
        chk(core_a_ctl[1:0] == 2'b00, "R7 not after one edge", 64'(core_a_ctl[1:0]), 64'd0);
        copies_same();
        @(negedge clk);
        chk(core_a_ctl[1:0] == 2'b11, "R7 after two edges", 64'(core_a_ctl[1:0]), 64'd3);
        nmbrk_async = 1'b1;
        irq_async = 1'b0;
        @(negedge clk);
        chk(core_a_ctl[2:0] == 3'b011, "R7 nmbrk and irq one edge", 64'(core_a_ctl[2:0]), 64'd3);
        @(negedge clk);
        chk(core_a_ctl[2:0] == 3'b110, "R7 nmbrk and irq two edges", 64'(core_a_ctl[2:0]), 64'd6);
        copies_same();

        // R8: reset lines assert without a clock edge, release after two edges
        #3;
        core_rst_async = 1'b1;
        #1;
        chk(core_a_ctl[3] == 1'b1, "R8 core reset immediate", 64'(core_a_ctl[3]), 64'd1);
        chk(core_a_ctl[4] == 1'b0, "R8 bus reset untouched", 64'(core_a_ctl[4]), 64'd0);
        bus_rst_async = 1'b1;
        #1;
        chk(core_a_ctl[4] == 1'b1, "R8 bus reset immediate", 64'(core_a_ctl[4]), 64'd1);
        copies_same();
        @(negedge clk);
        core_rst_async = 1'b0;
        bus_rst_async = 1'b0;
        @(negedge clk);
        chk(core_a_ctl[4:3] == 2'b11, "R8 held after one edge", 64'(core_a_ctl[4:3]), 64'd3);
        @(negedge clk);
        chk(core_a_ctl[4:3] == 2'b00, "R8 released after two edges", 64'(core_a_ctl[4:3]), 64'd0);
        chk(!fault, "R8 resets do not trip", 64'(fault), 64'd0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule